// File: doc/BRIEF.md
# Successive-Approximation ADC Controller with Power-Fail Compare

This block is the digital side of a 10-bit successive-approximation converter with eight selectable inputs. Software programs it through four small registers on a simple word bus: a mode register, a channel register, a read-only result register and a threshold register. Once the run and enable bits are both set, the controller drives a trial code to an external DAC and comparator. It decides one bit per step, most significant bit first, and the step length comes from a 3-bit conversion-time field. Conversions repeat on the selected channel for as long as the run bit stays set. Each completed result raises a one-cycle interrupt pulse.

A settling timer starts when the enable bit is set. A conversion that begins before the timer has expired still runs, but its result carries a stale flag. In power-fail mode every result is compared with the threshold register. The interrupt then fires only when the chosen condition holds (result below the threshold, or at or above it), and a flag output shows the outcome of the latest compare.

Two bus accesses can land in the same cycle as the end of a conversion. A result read is served first, and the new result is stored on the first cycle after the read ends. A mode or channel write discards the finishing result and its interrupt, and the conversion starts again.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset, all four registers read as zero, the bus is ready, the interrupt is low, the analog-power output is low and no conversion runs.
- R2: The analog-power output is high exactly when the run bit (mode bit 7) or the enable bit (mode bit 0) is set. With both cleared, no conversion runs and no interrupt is raised.
- R3: The time-select field (mode bits 5:3, value s) gives 2<<s clock cycles per bit. With the run bit held and no bus writes, consecutive interrupts are 10*(2<<s) cycles apart.
- R4: Each conversion begins with trial code 0x200 (MSB first). For a comparator that reports "input >= trial", the stored result (result register bits 9:0, address 2) equals the input level, including the levels 0 and 1023.
- R5: While run and enable stay set, conversions restart back to back on the current channel, with one interrupt per conversion.
- R6: When a result read (address 2) is held across the end of a conversion, the read keeps returning the old value and no interrupt is raised. On the first cycle after the read ends, the new value is stored and the interrupt pulses.
- R7: A write to the mode register (address 0) or the channel register (address 1) in the cycle where a conversion ends leaves the result unchanged and raises no interrupt. The conversion then restarts, and its result arrives normally.
- R8: A write to the threshold register (address 3, bits 9:0) holds bus-ready low for exactly one cycle. The value is loaded on the following cycle.
- R9: With power-fail mode on (mode bit 1), the interrupt fires only for results that match the condition. Mode bit 2 clear means result < threshold; mode bit 2 set means result >= threshold. The flag output shows whether the latest result matched.
- R10: A conversion that starts before SETTLE_CYCLES cycles have passed since the enable bit was set stores its result with the stale flag (result bit 15) set. Later conversions store it clear.
- R11: A channel write (bits 2:0) updates the channel output at once and aborts and restarts the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address: 0 mode, 1 channel, 2 result, 3 threshold |
| busWdata | input | 10 | Write data |
| busRdata | output | 16 | Read data of the addressed register |
| busReady | output | 1 | Low to stall the current access |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trialCode | output | 10 | Code driven to the DAC |
| chanSel | output | 3 | Selected analog input |
| analogOn | output | 1 | Analog section powered |
| irqEnd | output | 1 | Conversion-end interrupt pulse |
| pfFlag | output | 1 | Latest result matched the power-fail condition |

## Verification
The end of a conversion can fall in the same cycle as a result read, or in the same cycle as a mode or channel write. The conversion period is exact, so the bench times the next end of conversion from the previous interrupt pulse. It then holds a result read across that cycle, or places a write precisely on it. After changing the comparator's input level between conversions, it checks that the old result survives and whether the interrupt is delayed or suppressed. It then checks that the new level appears afterwards, either one cycle after the read or on the restarted conversion.

// File: rtl/adc_pkg.sv
`timescale 1ns/1ps
package adc_pkg;
  localparam int RES_W = 10;
  localparam int CH_W = 3;
  localparam int SEL_W = 3;
  localparam int RD_W = 16;
  localparam int CFG_W = 7;

  typedef enum logic [1:0] {
    A_MODE = 2'd0, A_CHAN = 2'd1, A_RESULT = 2'd2, A_THRESH = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic run;
    logic [SEL_W-1:0] timeSel;
    logic pfAbove;
    logic pfEn;
    logic en;
  } modeReg_t;

  typedef struct packed {
    logic start;
    logic step;
    logic last;
    logic stale;
    logic thrLoad;
    logic rdResult;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_ctrl.sv
`timescale 1ns/1ps
module adc_ctrl
  import adc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3500,
  parameter int BASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CFG_W-1:0] cfgData,
  output logic             busReady,
  output modeReg_t         mode,
  output logic [CH_W-1:0]  chanSel,
  output logic             analogOn,
  output ctlStrobe_t       strobe
);
  localparam int STL_W = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam int CNT_W = $clog2(BASE_CYC << ((1 << SEL_W) - 1)) + 1;
  localparam int BIT_W = $clog2(RES_W);

  typedef enum logic {S_IDLE, S_CONV} state_e;
  state_e state;

  logic wrAcc, modeWr, chanWr, thrReq, waitDone, abort, active, settled;
  logic staleReg;
  logic [STL_W-1:0] settleCnt;
  logic [CNT_W-1:0] cycCnt, cpb;
  logic [BIT_W-1:0] bitIdx;
  logic start, step, last;

  assign wrAcc  = busSel && busWr;
  assign modeWr = wrAcc && (busAddr == A_MODE);
  assign chanWr = wrAcc && (busAddr == A_CHAN);
  assign thrReq = wrAcc && (busAddr == A_THRESH);
  assign busReady = !(thrReq && !waitDone);
  assign abort  = modeWr || chanWr;
  assign active = mode.run && mode.en;
  assign analogOn = mode.run || mode.en;
  assign settled = (settleCnt == STL_W'(SETTLE_CYCLES));
  assign cpb = CNT_W'(BASE_CYC) << mode.timeSel;

  // bus side registers and the one-cycle wait for threshold writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= '0;
      chanSel <= '0;
      waitDone <= 1'b0;
    end else begin
      waitDone <= thrReq && !waitDone;
      if (modeWr) begin
        mode.run     <= cfgData[6];
        mode.timeSel <= cfgData[5:3];
        mode.pfAbove <= cfgData[2];
        mode.pfEn    <= cfgData[1];
        mode.en      <= cfgData[0];
      end
      if (chanWr) chanSel <= cfgData[CH_W-1:0];
    end
  end

  // settling timer restarted by the enable bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleCnt <= '0;
    else if (!mode.en) settleCnt <= '0;
    else if (!settled) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    start = 1'b0;
    step  = 1'b0;
    last  = 1'b0;
    if (!abort) begin
      if (state == S_IDLE) begin
        start = active;
      end else if (cycCnt == cpb - CNT_W'(1)) begin
        step  = 1'b1;
        last  = (bitIdx == '0);
        start = last && active;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cycCnt <= '0;
      bitIdx <= '0;
      staleReg <= 1'b0;
    end else if (abort) begin
      state <= S_IDLE;
      cycCnt <= '0;
    end else if (start) begin
      state <= S_CONV;
      cycCnt <= '0;
      bitIdx <= BIT_W'(RES_W - 1);
      staleReg <= !settled;
    end else if (state == S_CONV) begin
      if (step) begin
        cycCnt <= '0;
        if (last) state <= S_IDLE;
        else bitIdx <= bitIdx - 1'b1;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  assign strobe.start    = start;
  assign strobe.step     = step;
  assign strobe.last     = last;
  assign strobe.stale    = staleReg;
  assign strobe.thrLoad  = thrReq && waitDone;
  assign strobe.rdResult = busSel && !busWr && (busAddr == A_RESULT);

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr || chanWr) |=> (state == S_IDLE));
  p_stall_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busReady |=> busReady);
  p_off_is_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !analogOn |-> (state == S_IDLE));
endmodule

// File: rtl/adc_datapath.sv
`timescale 1ns/1ps
module adc_datapath
  import adc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic             pfEn,
  input  logic             pfAbove,
  input  logic             cmpIn,
  input  logic [RES_W-1:0] thrData,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] resultVal,
  output logic             resultStale,
  output logic [RES_W-1:0] thresh,
  output logic             irqEnd,
  output logic             pfFlag
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar, mask, decided, pendVal, commitVal;
  logic pendValid, pendStale, eoc, commit, commitStale, match;

  assign decided = cmpIn ? sar : (sar & ~mask);
  assign eoc = strobe.step && strobe.last;
  assign trialCode = sar;

  // successive approximation register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sar <= '0;
      mask <= '0;
    end else if (strobe.start) begin
      sar <= MSB;
      mask <= MSB;
    end else if (strobe.step) begin
      sar <= decided | (mask >> 1);
      mask <= mask >> 1;
    end
  end

  // a result read holds back the hardware write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendVal <= '0;
      pendStale <= 1'b0;
    end else if (eoc && strobe.rdResult) begin
      pendValid <= 1'b1;
      pendVal <= decided;
      pendStale <= strobe.stale;
    end else if (!strobe.rdResult) begin
      pendValid <= 1'b0;
    end
  end

  assign commit = !strobe.rdResult && (eoc || pendValid);
  assign commitVal = eoc ? decided : pendVal;
  assign commitStale = eoc ? strobe.stale : pendStale;
  assign match = pfAbove ? (commitVal >= thresh) : (commitVal < thresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultVal <= '0;
      resultStale <= 1'b0;
      irqEnd <= 1'b0;
      pfFlag <= 1'b0;
      thresh <= '0;
    end else begin
      irqEnd <= commit && (!pfEn || match);
      if (commit) begin
        resultVal <= commitVal;
        resultStale <= commitStale;
        pfFlag <= pfEn && match;
      end
      if (strobe.thrLoad) thresh <= thrData;
    end
  end

  p_read_holds_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdResult |=> $stable(resultVal));
  p_irq_needs_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(eoc || pendValid) |=> !irqEnd);
  p_pf_flag_with_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnd && $past(pfEn)) |-> pfFlag);
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> (trialCode == MSB));
endmodule

// File: rtl/adc_ctrl_top.sv
`timescale 1ns/1ps
module adc_ctrl_top
  import adc_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3500,
  parameter int BASE_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [9:0]  busWdata,
  output logic [15:0] busRdata,
  output logic        busReady,
  input  logic        cmpIn,
  output logic [9:0]  trialCode,
  output logic [2:0]  chanSel,
  output logic        analogOn,
  output logic        irqEnd,
  output logic        pfFlag
);
  modeReg_t mode;
  ctlStrobe_t strobe;
  logic [RES_W-1:0] resultVal, thresh;
  logic resultStale;

  adc_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES), .BASE_CYC(BASE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .cfgData({busWdata[7], busWdata[5:0]}), .busReady(busReady), .mode(mode),
    .chanSel(chanSel), .analogOn(analogOn), .strobe(strobe)
  );

  adc_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pfEn(mode.pfEn),
    .pfAbove(mode.pfAbove), .cmpIn(cmpIn), .thrData(busWdata),
    .trialCode(trialCode), .resultVal(resultVal), .resultStale(resultStale),
    .thresh(thresh), .irqEnd(irqEnd), .pfFlag(pfFlag)
  );

  always_comb begin
    case (busAddr)
      A_MODE:   busRdata = {8'b0, mode.run, 1'b0, mode.timeSel, mode.pfAbove, mode.pfEn, mode.en};
      A_CHAN:   busRdata = {{(RD_W-CH_W){1'b0}}, chanSel};
      A_RESULT: busRdata = {resultStale, {(RD_W-RES_W-1){1'b0}}, resultVal};
      default:  busRdata = {{(RD_W-RES_W){1'b0}}, thresh};
    endcase
  end
endmodule

// File: tb/test_adc_ctrl_top.sv
`timescale 1ns/1ps
module test_adc_ctrl_top;
  logic clk = 1'b0;
  logic rstN, busSel, busWr, cmpIn, busReady, analogOn, irqEnd, pfFlag;
  logic [1:0] busAddr;
  logic [9:0] busWdata, trialCode, analogLvl;
  logic [15:0] busRdata;
  logic [2:0] chanSel;
  int total = 0, bad = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;
  assign cmpIn = (analogLvl >= trialCode);

  adc_ctrl_top #(.SETTLE_CYCLES(30), .BASE_CYC(2)) i_adc_ctrl_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .cmpIn(cmpIn),
    .trialCode(trialCode), .chanSel(chanSel), .analogOn(analogOn),
    .irqEnd(irqEnd), .pfFlag(pfFlag)
  );

  function automatic int expPeriod(input int sel);
    return 10 * (2 << sel);
  endfunction
  function automatic bit expMatch(input int v, input int t, input bit above);
    return above ? (v >= t) : (v < t);
  endfunction
  function automatic logic [9:0] modeWord(input bit run, input int sel, input bit above,
                                          input bit pfe, input bit en);
    return {2'b0, run, 1'b0, 3'(sel), above, pfe, en};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [9:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    #1;
    while (!busReady) begin @(negedge clk); #1; end
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitIrq(input int maxCyc, output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!irqEnd && cyc < maxCyc);
  endtask

  task automatic countIrq(input int cyc, output int n);
    n = 0;
    repeat (cyc) begin @(negedge clk); if (irqEnd) n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int cyc, n, sel, per;
    logic [9:0] oldLvl, newLvl;
    void'($urandom(32'h5eed));
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0; analogLvl = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", busReady, 1);
    check("R1 irq", irqEnd, 0);
    check("R1 analogOn", analogOn, 0);
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), rd);
      check("R1 register zero", rd, 0);
    end

    // R8 threshold write stalls one cycle
    busSel = 1'b1; busWr = 1'b1; busAddr = 2'd3; busWdata = 10'd512;
    #1 check("R8 first cycle stalled", busReady, 0);
    @(negedge clk); #1 check("R8 second cycle ready", busReady, 1);
    @(negedge clk); busSel = 1'b0; busWr = 1'b0;
    readReg(2'd3, rd);
    check("R8 threshold loaded", rd, 512);

    // R10 start together with enable: first result stale
    analogLvl = 10'd321;
    busWrite(2'd0, modeWord(1, 2, 0, 0, 1));
    check("R2 analogOn set", analogOn, 1);
    @(negedge clk);
    check("R4 first trial is MSB", trialCode, 10'h200);
    waitIrq(400, cyc);
    readReg(2'd2, rd);
    check("R4 result value", rd[9:0], 321);
    check("R10 first result stale", rd[15], 1);
    waitIrq(400, cyc);
    check("R3 period sel2", cyc, expPeriod(2));
    readReg(2'd2, rd);
    check("R10 settled result clean", rd[15], 0);
    check("R5 repeated result", rd[9:0], 321);

    // random channels, levels and conversion times
    for (int i = 0; i < 6; i++) begin
      int ch;
      sel = $urandom % 4;
      ch = $urandom % 8;
      analogLvl = (i == 0) ? 10'd0 : (i == 1) ? 10'd1023 : 10'($urandom % 1024);
      busWrite(2'd1, 10'(ch));
      check("R11 channel output", chanSel, ch);
      busWrite(2'd0, modeWord(1, sel, 0, 0, 1));
      waitIrq(400, cyc);
      waitIrq(400, cyc);
      check("R3 period", cyc, expPeriod(sel));
      readReg(2'd2, rd);
      check("R4 result equals level", rd[9:0], analogLvl);
      waitIrq(400, cyc);
      check("R5 auto restart period", cyc, expPeriod(sel));
    end

    // R6 read held across end of conversion
    busWrite(2'd0, modeWord(1, 1, 0, 0, 1));
    per = expPeriod(1);
    waitIrq(400, cyc);
    waitIrq(400, cyc);
    oldLvl = analogLvl; newLvl = oldLvl ^ 10'h155; analogLvl = newLvl;
    repeat (per - 3) @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 2'd2;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R6 read returns old", busRdata[9:0], oldLvl);
      check("R6 no irq during read", irqEnd, 0);
    end
    busSel = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 irq after read", irqEnd, 1);
    readReg(2'd2, rd);
    check("R6 new value after read", rd[9:0], newLvl);

    // R7 mode write on end of conversion
    waitIrq(400, cyc);
    oldLvl = analogLvl; newLvl = oldLvl ^ 10'h2AA; analogLvl = newLvl;
    repeat (per - 1) @(posedge clk);
    @(negedge clk);
    busWrite(2'd0, modeWord(1, 1, 0, 0, 1));
    check("R7 mode write suppresses irq", irqEnd, 0);
    readReg(2'd2, rd);
    check("R7 mode write keeps result", rd[9:0], oldLvl);
    waitIrq(400, cyc);
    readReg(2'd2, rd);
    check("R7 restarted result", rd[9:0], newLvl);

    // R7 / R11 channel write on end of conversion
    oldLvl = analogLvl; newLvl = oldLvl + 10'd77; analogLvl = newLvl;
    repeat (per - 1) @(posedge clk);
    @(negedge clk);
    busWrite(2'd1, 10'd5);
    check("R7 channel write suppresses irq", irqEnd, 0);
    check("R11 channel switched", chanSel, 5);
    readReg(2'd2, rd);
    check("R7 channel write keeps result", rd[9:0], oldLvl);
    waitIrq(400, cyc);
    check("R11 restart period", cyc, per + 1);
    readReg(2'd2, rd);
    check("R11 result on new channel", rd[9:0], newLvl);

    // R9 power-fail compare
    busWrite(2'd3, 10'd500);
    for (int k = 0; k < 7; k++) begin
      int lv; bit ab;
      case (k)
        0: begin lv = 300; ab = 0; end
        1: begin lv = 700; ab = 0; end
        2: begin lv = 500; ab = 0; end
        3: begin lv = 499; ab = 0; end
        4: begin lv = 500; ab = 1; end
        5: begin lv = 499; ab = 1; end
        default: begin lv = 700; ab = 1; end
      endcase
      analogLvl = 10'(lv);
      busWrite(2'd0, modeWord(1, 0, ab, 1, 1));
      countIrq(70, n);
      check("R9 irq on match", int'(n > 0), int'(expMatch(lv, 500, ab)));
      check("R9 flag", pfFlag, int'(expMatch(lv, 500, ab)));
    end

    // R2 both bits cleared
    busWrite(2'd0, 10'd0);
    check("R2 analogOn cleared", analogOn, 0);
    countIrq(100, n);
    check("R2 no irq when off", n, 0);

    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule